// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block is a controller state machine that takes a freshly powered SD card into SPI mode and works out what kind of card it is. It has no SPI shifter of its own. It hands each step to a separate command transaction engine through a one-cycle request and a one-cycle response. Each step is either a run of idle clocks with chip select high, or a command with an index and a 32-bit argument. The engine returns the R1 status byte and, for commands that carry extra bytes, a 32-bit payload. When the engine gets no reply from the card, it reports an R1 value with bit 7 set (0xFF).

A `start` pulse launches the sequence. The block runs these steps in order:

- It issues the idle-clock preamble.
- It resets the card, retrying after a wait if needed.
- It probes the interface condition to tell first-generation cards from second-generation cards.
- It reads the operating-condition register to check 3.3 V support.
- It polls the application-specific operating-condition command until the card leaves idle.
- On second-generation cards, it reads the capacity flag.
- Finally, it sets a 512-byte block length.

The outcome is reported on three outputs: a card-type code, a done flag and a one-hot error vector. The block also reports the SPI clock rate the engine should use: slow during bring-up, and the fast rate (capped at 25 MHz) once bring-up succeeds. A new `start` from the done or failed state runs the sequence again.

Top module: `sd_bringup_seq`

## Requirements
- R1: After reset `card_type` is 0, `init_done` is 0, `err` is 0, `req_valid` is 0 and `sclk_hz` equals SLOW_CLK_HZ.
- R2: A `start` pulse makes the first request a preamble (`req_preamble`=1). Every request is a single-cycle `req_valid` pulse. `sclk_hz` stays at SLOW_CLK_HZ while requests are issued.
- R3: Reset command 0 is sent with argument 0, for up to CMD0_TRIES attempts. Any R1 other than exactly 0x01 counts as a failed attempt. At least CMD0_GAP_CYCLES cycles separate a failed attempt's response from the next request. If every attempt fails, `err` becomes 4'b0001 (no device) and `card_type` becomes 0.
- R4: Command 8 is sent with argument 0x1AA. An R1 with bit 2 (illegal) set selects the first-generation path. Any other R1 marks a second-generation card, whose payload bits 11:0 must equal 0x1AA. If they do not, `err` becomes 4'b0010 (unusable) and `card_type` becomes 4.
- R5: Command 58 is then sent with argument 0. If payload bit 20 (3.3 V) is clear, `err` becomes 4'b0010 and `card_type` becomes 4.
- R6: Each command 41 is preceded by command 55 with argument 0. Command 41's argument is 0x4000_0000 on second-generation cards and 0 otherwise. The pair is repeated while the command 41 R1 equals 0x01.
- R7: If command 41 still reports idle once OPCOND_TIMEOUT_CYCLES have passed since the first command 55, `err` becomes 4'b0100 (timeout) and `card_type` becomes 4.
- R8: After the reset step, a non-idle command 41 R1 other than 0x00, a command 16 R1 other than 0x00, or any R1 with bit 3 (CRC) set gives `err` 4'b1000 and `card_type` 4. Bit 2 (illegal) set gives the same result on any of these commands except command 8. An R1 with bit 7 set gives `err` 4'b0001 and `card_type` 0.
- R9: A first-generation card that leaves idle gets `card_type` 1. A second-generation card gets a second command 58: payload bit 30 set gives `card_type` 3, clear gives 2.
- R10: Command 16 is sent with argument 512. An R1 of 0x00 sets `init_done`, keeps `err` at 0, and sets `sclk_hz` to the smaller of FAST_REQ_HZ and FAST_CAP_HZ.
- R11: `err` never has more than one bit set. `init_done` is never 1 while `err` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (accepted when idle, done or failed) |
| req_valid | output | 1 | One-cycle request to the transaction engine |
| req_preamble | output | 1 | Request is the idle-clock preamble with chip select high |
| req_cmd | output | 6 | Command index of the request |
| req_arg | output | 32 | Command argument of the request |
| rsp_valid | input | 1 | One-cycle response strobe from the engine |
| rsp_r1 | input | 8 | R1 status byte; bit 7 set means no reply |
| rsp_data | input | 32 | Extra response payload (interface condition echo or operating-condition register) |
| card_type | output | 3 | 0 none, 1 first-gen, 2 second-gen standard, 3 second-gen high capacity, 4 unknown |
| init_done | output | 1 | Bring-up finished successfully |
| err | output | 4 | One-hot: bit 0 no device, bit 1 unusable, bit 2 timeout, bit 3 command failed |
| sclk_hz | output | 32 | SPI clock rate the engine should use |

## Verification
The hardest state to reach is the command 41 timeout. The polling timer is only armed once the card has passed the reset, interface-condition and voltage steps, and it only fires if the card keeps answering "idle" for the whole window. The bench shortens the window through the parameter. A bus model then walks the sequence up to the polling loop and keeps answering 0x01 to every command 41 until the error appears, counting how many rounds it took. The reset-retry wait is reached the same way: the model answers 0xFF and then 0x00 before 0x01, and counts the cycles between each response and the next request.

// File: rtl/sd_bringup_pkg.sv
package sd_bringup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_RST,
        ST_GAP,
        ST_IFC,
        ST_OCR1,
        ST_APP,
        ST_OPC,
        ST_OCR2,
        ST_BLEN,
        ST_DONE,
        ST_FAIL
    } seq_st_e;

    localparam logic [5:0] CMD_GO_IDLE  = 6'd0;
    localparam logic [5:0] CMD_IF_COND  = 6'd8;
    localparam logic [5:0] CMD_BLOCKLEN = 6'd16;
    localparam logic [5:0] CMD_OP_COND  = 6'd41;
    localparam logic [5:0] CMD_APP      = 6'd55;
    localparam logic [5:0] CMD_READ_OCR = 6'd58;

    localparam logic [31:0] IF_COND_ARG = 32'h0000_01AA;
    localparam logic [31:0] BLOCK_BYTES = 32'd512;
    localparam logic [31:0] HCS_ARG     = 32'h4000_0000;

    localparam logic [2:0] CT_NONE    = 3'd0;
    localparam logic [2:0] CT_V1      = 3'd1;
    localparam logic [2:0] CT_V2SC    = 3'd2;
    localparam logic [2:0] CT_V2HC    = 3'd3;
    localparam logic [2:0] CT_UNKNOWN = 3'd4;

    localparam logic [3:0] ERR_NODEV    = 4'b0001;
    localparam logic [3:0] ERR_UNUSABLE = 4'b0010;
    localparam logic [3:0] ERR_TIMEOUT  = 4'b0100;
    localparam logic [3:0] ERR_CMDFAIL  = 4'b1000;

endpackage

// File: rtl/sd_r1_classify.sv
module sd_r1_classify (
    input  logic [7:0] r1,
    output logic       none,
    output logic       illegal,
    output logic       crc_bad,
    output logic       idle,
    output logic       clean,
    output logic       idle_only
);
    always_comb begin
        none      = r1[7];
        illegal   = r1[2];
        crc_bad   = r1[3];
        idle      = r1[0];
        clean     = (r1 == 8'h00);
        idle_only = (r1 == 8'h01);
    end
endmodule

// File: rtl/sd_cycle_timer.sv
module sd_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sd_bringup_seq.sv
module sd_bringup_seq
    import sd_bringup_pkg::*;
#(
    parameter int CMD0_TRIES            = 5,
    parameter int CMD0_GAP_CYCLES       = 125_000,
    parameter int OPCOND_TIMEOUT_CYCLES = 125_000_000,
    parameter int SLOW_CLK_HZ           = 400_000,
    parameter int FAST_REQ_HZ           = 50_000_000,
    parameter int FAST_CAP_HZ           = 25_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        req_valid,
    output logic        req_preamble,
    output logic [5:0]  req_cmd,
    output logic [31:0] req_arg,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_r1,
    input  logic [31:0] rsp_data,
    output logic [2:0]  card_type,
    output logic        init_done,
    output logic [3:0]  err,
    output logic [31:0] sclk_hz
);
    localparam int TRY_W   = $clog2(CMD0_TRIES + 1);
    localparam int GAP_W   = $clog2(CMD0_GAP_CYCLES + 1);
    localparam int TO_W    = $clog2(OPCOND_TIMEOUT_CYCLES + 1);
    localparam int FAST_HZ = (FAST_REQ_HZ > FAST_CAP_HZ) ? FAST_CAP_HZ : FAST_REQ_HZ;

    typedef struct packed {
        seq_st_e          st;
        logic             issued;
        logic [TRY_W-1:0] tries;
        logic             v2;
        logic [2:0]       ctype;
        logic [3:0]       err;
        logic             fast;
    } seq_regs_t;

    function automatic seq_regs_t fail_to(seq_regs_t s, logic [3:0] e, logic [2:0] t);
        seq_regs_t r;
        r        = s;
        r.st     = ST_FAIL;
        r.issued = 1'b0;
        r.err    = e;
        r.ctype  = t;
        return r;
    endfunction

    seq_regs_t d, q;
    logic r1_none, r1_illegal, r1_crc, r1_idle, r1_clean, r1_idle_only;
    logic gap_load, gap_expired, to_load, to_expired;
    logic cmd_state, got;
    logic data_unused;

    assign data_unused = ^{rsp_data[31], rsp_data[29:21], rsp_data[19:12]};

    sd_r1_classify u_r1 (
        .r1        (rsp_r1),
        .none      (r1_none),
        .illegal   (r1_illegal),
        .crc_bad   (r1_crc),
        .idle      (r1_idle),
        .clean     (r1_clean),
        .idle_only (r1_idle_only)
    );

    sd_cycle_timer #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (GAP_W'(CMD0_GAP_CYCLES)),
        .expired  (gap_expired)
    );

    sd_cycle_timer #(.W(TO_W)) u_opc_to (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (to_load),
        .load_val (TO_W'(OPCOND_TIMEOUT_CYCLES)),
        .expired  (to_expired)
    );

    always_comb begin
        d            = q;
        gap_load     = 1'b0;
        to_load      = 1'b0;
        req_valid    = 1'b0;
        req_preamble = 1'b0;
        req_cmd      = CMD_GO_IDLE;
        req_arg      = '0;
        cmd_state    = 1'b1;

        // request fields per state
        case (q.st)
            ST_PRE:  req_preamble = 1'b1;
            ST_RST:  req_cmd = CMD_GO_IDLE;
            ST_IFC:  begin req_cmd = CMD_IF_COND;  req_arg = IF_COND_ARG; end
            ST_OCR1: req_cmd = CMD_READ_OCR;
            ST_APP:  req_cmd = CMD_APP;
            ST_OPC:  begin req_cmd = CMD_OP_COND;  req_arg = q.v2 ? HCS_ARG : '0; end
            ST_OCR2: req_cmd = CMD_READ_OCR;
            ST_BLEN: begin req_cmd = CMD_BLOCKLEN; req_arg = BLOCK_BYTES; end
            default: cmd_state = 1'b0;
        endcase

        if (cmd_state && !q.issued) begin
            req_valid = 1'b1;
            d.issued  = 1'b1;
        end
        got = cmd_state && q.issued && rsp_valid;

        // transitions
        case (q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    d.st     = ST_PRE;
                    d.issued = 1'b0;
                    d.tries  = '0;
                    d.v2     = 1'b0;
                    d.ctype  = CT_NONE;
                    d.err    = '0;
                    d.fast   = 1'b0;
                end
            end
            ST_PRE: if (got) begin d.st = ST_RST; d.issued = 1'b0; end
            ST_RST: if (got) begin
                d.issued = 1'b0;
                if (r1_idle_only)
                    d.st = ST_IFC;
                else if (q.tries == TRY_W'(CMD0_TRIES - 1))
                    d = fail_to(q, ERR_NODEV, CT_NONE);
                else begin
                    d.tries  = q.tries + 1'b1;
                    d.st     = ST_GAP;
                    gap_load = 1'b1;
                end
            end
            ST_GAP: if (gap_expired) d.st = ST_RST;
            default: if (got) begin
                d.issued = 1'b0;
                if (r1_none)
                    d = fail_to(q, ERR_NODEV, CT_NONE);
                else if (r1_crc || (r1_illegal && q.st != ST_IFC))
                    d = fail_to(q, ERR_CMDFAIL, CT_UNKNOWN);
                else begin
                    case (q.st)
                        ST_IFC: begin
                            if (r1_illegal) begin
                                d.v2 = 1'b0;
                                d.st = ST_OCR1;
                            end else if (rsp_data[11:0] != IF_COND_ARG[11:0])
                                d = fail_to(q, ERR_UNUSABLE, CT_UNKNOWN);
                            else begin
                                d.v2    = 1'b1;
                                d.ctype = CT_V2SC;
                                d.st    = ST_OCR1;
                            end
                        end
                        ST_OCR1: begin
                            if (!rsp_data[20])
                                d = fail_to(q, ERR_UNUSABLE, CT_UNKNOWN);
                            else begin
                                d.st    = ST_APP;
                                to_load = 1'b1;
                            end
                        end
                        ST_APP: d.st = ST_OPC;
                        ST_OPC: begin
                            if (r1_idle) begin
                                if (to_expired)
                                    d = fail_to(q, ERR_TIMEOUT, CT_UNKNOWN);
                                else
                                    d.st = ST_APP;
                            end else if (!r1_clean)
                                d = fail_to(q, ERR_CMDFAIL, CT_UNKNOWN);
                            else if (q.v2)
                                d.st = ST_OCR2;
                            else begin
                                d.ctype = CT_V1;
                                d.st    = ST_BLEN;
                            end
                        end
                        ST_OCR2: begin
                            d.ctype = rsp_data[30] ? CT_V2HC : CT_V2SC;
                            d.st    = ST_BLEN;
                        end
                        ST_BLEN: begin
                            if (!r1_clean)
                                d = fail_to(q, ERR_CMDFAIL, CT_UNKNOWN);
                            else begin
                                d.st   = ST_DONE;
                                d.fast = 1'b1;
                            end
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.issued <= 1'b0;
            q.tries  <= '0;
            q.v2     <= 1'b0;
            q.ctype  <= CT_NONE;
            q.err    <= '0;
            q.fast   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign card_type = q.ctype;
    assign err       = q.err;
    assign init_done = (q.st == ST_DONE);
    assign sclk_hz   = q.fast ? 32'(FAST_HZ) : 32'(SLOW_CLK_HZ);
endmodule

// File: rtl/sd_bringup_chk.sv
module sd_bringup_chk #(
    parameter int SLOW_HZ = 400_000,
    parameter int FAST_HZ = 25_000_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_preamble,
    input logic [5:0]  req_cmd,
    input logic [31:0] req_arg,
    input logic [2:0]  card_type,
    input logic        init_done,
    input logic [3:0]  err,
    input logic [31:0] sclk_hz
);
    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R2
    slow_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> sclk_hz == 32'(SLOW_HZ));

    // R3
    reset_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_preamble && req_cmd == 6'd0) |-> req_arg == 32'h0);

    // R4
    ifcond_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 6'd8) |-> req_arg == 32'h0000_01AA);

    // R6
    opcond_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 6'd41) |-> (req_arg & 32'hBFFF_FFFF) == 32'h0);

    // R9
    done_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (card_type >= 3'd1 && card_type <= 3'd3));

    // R10
    fast_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> sclk_hz == 32'(FAST_HZ));

    // R11
    err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err));

    // R11
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> err == 4'b0000);
endmodule

bind sd_bringup_seq sd_bringup_chk #(
    .SLOW_HZ (SLOW_CLK_HZ),
    .FAST_HZ (FAST_HZ)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_preamble (req_preamble),
    .req_cmd      (req_cmd),
    .req_arg      (req_arg),
    .card_type    (card_type),
    .init_done    (init_done),
    .err          (err),
    .sclk_hz      (sclk_hz)
);

// File: tb/sd_bringup_seq_test.sv
`timescale 1ns/1ps
module sd_bringup_seq_test;
    localparam int TRIES = 5;
    localparam int GAP   = 6;
    localparam int TOUT  = 60;
    localparam int SLOW  = 400_000;
    localparam int FREQ  = 50_000_000;
    localparam int FAST  = 25_000_000;
    localparam logic [31:0] HCS = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_valid, req_preamble;
    logic [5:0]  req_cmd;
    logic [31:0] req_arg;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_r1 = 8'h00;
    logic [31:0] rsp_data = 32'h0;
    logic [2:0]  card_type;
    logic        init_done;
    logic [3:0]  err;
    logic [31:0] sclk_hz;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sd_bringup_seq #(
        .CMD0_TRIES(TRIES), .CMD0_GAP_CYCLES(GAP), .OPCOND_TIMEOUT_CYCLES(TOUT),
        .SLOW_CLK_HZ(SLOW), .FAST_REQ_HZ(FREQ), .FAST_CAP_HZ(FAST)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_preamble(req_preamble), .req_cmd(req_cmd), .req_arg(req_arg),
        .rsp_valid(rsp_valid), .rsp_r1(rsp_r1), .rsp_data(rsp_data),
        .card_type(card_type), .init_done(init_done), .err(err), .sclk_hz(sclk_hz)
    );

    typedef struct packed {
        logic        ill8;
        logic [11:0] echo;
        logic        v33;
        logic [1:0]  idle_n;
        logic        ccs;
        logic [2:0]  etype;
        logic [3:0]  eerr;
        logic        edone;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{1'b1, 12'h000, 1'b1, 2'd2, 1'b0, 3'd1, 4'b0000, 1'b1},
        '{1'b0, 12'h1AA, 1'b1, 2'd1, 1'b0, 3'd2, 4'b0000, 1'b1},
        '{1'b0, 12'h1AA, 1'b1, 2'd3, 1'b1, 3'd3, 4'b0000, 1'b1},
        '{1'b0, 12'h2AA, 1'b1, 2'd0, 1'b0, 3'd4, 4'b0010, 1'b0},
        '{1'b0, 12'h1AA, 1'b0, 2'd0, 1'b0, 3'd4, 4'b0010, 1'b0},
        '{1'b1, 12'h000, 1'b0, 2'd0, 1'b0, 3'd4, 4'b0010, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic take_req(input bit pre, input logic [5:0] cmd, input logic [31:0] arg, input string tag);
        while (!req_valid) @(negedge clk);
        if (pre) begin
            chk(req_preamble == 1'b1, tag, 32'(req_preamble), 32'd1);
        end else begin
            chk(req_preamble == 1'b0 && req_cmd == cmd, tag, 32'(req_cmd), 32'(cmd));
            chk(req_arg == arg, tag, req_arg, arg);
        end
    endtask

    task automatic give(input logic [7:0] r1, input logic [31:0] data);
        repeat (2) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_r1    = r1;
        rsp_data  = data;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_r1    = 8'h00;
        rsp_data  = 32'h0;
    endtask

    task automatic xfer(input bit pre, input logic [5:0] cmd, input logic [31:0] arg,
                        input logic [7:0] r1, input logic [31:0] data, input string tag);
        take_req(pre, cmd, arg, tag);
        give(r1, data);
    endtask

    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic outcome(input logic [2:0] t, input logic [3:0] e, input logic dn, input string tag);
        @(negedge clk);
        chk(card_type == t, {tag, " type"}, 32'(card_type), 32'(t));
        chk(err == e, {tag, " err"}, 32'(err), 32'(e));
        chk(init_done == dn, {tag, " done"}, 32'(init_done), 32'(dn));
        chk($countones(err) <= 1, "R11 err one-hot", 32'(err), 32'(e));
        chk(sclk_hz == (dn ? 32'(FAST) : 32'(SLOW)), "R10 clock rate", sclk_hz, dn ? 32'(FAST) : 32'(SLOW));
    endtask

    task automatic run_row(input row_t r);
        kick();
        xfer(1'b1, 6'd0, 32'h0, 8'h00, 32'h0, "R2 preamble first");
        xfer(1'b0, 6'd0, 32'h0, 8'h01, 32'h0, "R3 reset cmd");
        take_req(1'b0, 6'd8, 32'h1AA, "R4 if-cond cmd");
        give(r.ill8 ? 8'h05 : 8'h01, {20'h0, r.echo});
        if (!r.ill8 && r.echo != 12'h1AA) begin
            outcome(r.etype, r.eerr, r.edone, "R4 echo mismatch");
            return;
        end
        xfer(1'b0, 6'd58, 32'h0, 8'h01, {11'h0, r.v33, 20'h0}, "R5 ocr read");
        if (!r.v33) begin
            outcome(r.etype, r.eerr, r.edone, "R5 no 3.3V");
            return;
        end
        for (int i = 0; i < int'(r.idle_n); i++) begin
            xfer(1'b0, 6'd55, 32'h0, 8'h01, 32'h0, "R6 app prefix");
            xfer(1'b0, 6'd41, r.ill8 ? 32'h0 : HCS, 8'h01, 32'h0, "R6 opcond idle");
        end
        xfer(1'b0, 6'd55, 32'h0, 8'h01, 32'h0, "R6 app prefix");
        xfer(1'b0, 6'd41, r.ill8 ? 32'h0 : HCS, 8'h00, 32'h0, "R6 opcond ready");
        if (!r.ill8)
            xfer(1'b0, 6'd58, 32'h0, 8'h00, {1'b0, r.ccs, 30'h0}, "R9 capacity read");
        xfer(1'b0, 6'd16, 32'd512, 8'h00, 32'h0, "R10 block length");
        outcome(r.etype, r.eerr, r.edone, "R9 classification");
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int gap_cnt;
        int rounds;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(card_type == 3'd0, "R1 reset type", 32'(card_type), 32'd0);
        chk(init_done == 1'b0, "R1 reset done", 32'(init_done), 32'd0);
        chk(err == 4'd0, "R1 reset err", 32'(err), 32'd0);
        chk(req_valid == 1'b0, "R1 reset req", 32'(req_valid), 32'd0);
        chk(sclk_hz == 32'(SLOW), "R1 reset clock", sclk_hz, 32'(SLOW));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "R1 no request without start", 32'(req_valid), 32'd0);

        // table of card behaviours
        for (int k = 0; k < 6; k++) run_row(ROWS[k]);

        // R3 retries: 0xFF then 0x00 then 0x01, measuring the gaps; then R8 no reply on cmd 8
        kick();
        xfer(1'b1, 6'd0, 32'h0, 8'h00, 32'h0, "R2 preamble first");
        xfer(1'b0, 6'd0, 32'h0, 8'hFF, 32'h0, "R3 reset try 1");
        gap_cnt = 0;
        while (!req_valid) begin @(negedge clk); gap_cnt++; end
        chk(gap_cnt >= GAP, "R3 retry gap", 32'(gap_cnt), 32'(GAP));
        xfer(1'b0, 6'd0, 32'h0, 8'h00, 32'h0, "R3 reset try 2");
        gap_cnt = 0;
        while (!req_valid) begin @(negedge clk); gap_cnt++; end
        chk(gap_cnt >= GAP, "R3 retry gap after 0x00", 32'(gap_cnt), 32'(GAP));
        xfer(1'b0, 6'd0, 32'h0, 8'h01, 32'h0, "R3 reset try 3");
        xfer(1'b0, 6'd8, 32'h1AA, 8'hFF, 32'h0, "R4 if-cond cmd");
        outcome(3'd0, 4'b0001, 1'b0, "R8 no reply");

        // R3 all attempts fail
        kick();
        xfer(1'b1, 6'd0, 32'h0, 8'h00, 32'h0, "R2 preamble first");
        for (int i = 0; i < TRIES; i++)
            xfer(1'b0, 6'd0, 32'h0, 8'hFF, 32'h0, "R3 reset attempt");
        outcome(3'd0, 4'b0001, 1'b0, "R3 no device");
        repeat (GAP + 4) @(negedge clk);
        chk(req_valid == 1'b0 && err == 4'b0001, "R3 no sixth attempt", 32'(req_valid), 32'd0);

        // R7 opcond timeout on a second-generation card
        kick();
        xfer(1'b1, 6'd0, 32'h0, 8'h00, 32'h0, "R2 preamble first");
        xfer(1'b0, 6'd0, 32'h0, 8'h01, 32'h0, "R3 reset cmd");
        xfer(1'b0, 6'd8, 32'h1AA, 8'h01, 32'h1AA, "R4 if-cond cmd");
        xfer(1'b0, 6'd58, 32'h0, 8'h01, 32'h0010_0000, "R5 ocr read");
        rounds = 0;
        for (int i = 0; i < 40; i++) begin
            xfer(1'b0, 6'd55, 32'h0, 8'h01, 32'h0, "R6 app prefix");
            xfer(1'b0, 6'd41, HCS, 8'h01, 32'h0, "R7 opcond poll");
            rounds++;
            if (err != 4'd0) break;
        end
        chk(rounds >= 2, "R7 polled more than once", 32'(rounds), 32'd2);
        outcome(3'd4, 4'b0100, 1'b0, "R7 timeout");

        // R8 illegal on opcond (first-generation card)
        kick();
        xfer(1'b1, 6'd0, 32'h0, 8'h00, 32'h0, "R2 preamble first");
        xfer(1'b0, 6'd0, 32'h0, 8'h01, 32'h0, "R3 reset cmd");
        xfer(1'b0, 6'd8, 32'h1AA, 8'h05, 32'h0, "R4 illegal selects v1");
        xfer(1'b0, 6'd58, 32'h0, 8'h01, 32'h0010_0000, "R5 ocr read");
        xfer(1'b0, 6'd55, 32'h0, 8'h01, 32'h0, "R6 app prefix");
        xfer(1'b0, 6'd41, 32'h0, 8'h04, 32'h0, "R8 opcond illegal");
        outcome(3'd4, 4'b1000, 1'b0, "R8 opcond rejected");

        // R8 block length rejected
        kick();
        xfer(1'b1, 6'd0, 32'h0, 8'h00, 32'h0, "R2 preamble first");
        xfer(1'b0, 6'd0, 32'h0, 8'h01, 32'h0, "R3 reset cmd");
        xfer(1'b0, 6'd8, 32'h1AA, 8'h05, 32'h0, "R4 illegal selects v1");
        xfer(1'b0, 6'd58, 32'h0, 8'h01, 32'h0010_0000, "R5 ocr read");
        xfer(1'b0, 6'd55, 32'h0, 8'h01, 32'h0, "R6 app prefix");
        xfer(1'b0, 6'd41, 32'h0, 8'h00, 32'h0, "R6 opcond ready");
        xfer(1'b0, 6'd16, 32'd512, 8'h40, 32'h0, "R10 block length");
        outcome(3'd4, 4'b1000, 1'b0, "R8 block length rejected");

        // R8 CRC flag on the first ocr read
        kick();
        xfer(1'b1, 6'd0, 32'h0, 8'h00, 32'h0, "R2 preamble first");
        xfer(1'b0, 6'd0, 32'h0, 8'h01, 32'h0, "R3 reset cmd");
        xfer(1'b0, 6'd8, 32'h1AA, 8'h01, 32'h1AA, "R4 if-cond cmd");
        xfer(1'b0, 6'd58, 32'h0, 8'h09, 32'h0010_0000, "R5 ocr read");
        outcome(3'd4, 4'b1000, 1'b0, "R8 crc flag");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule